// File: doc/BRIEF.md
# Mergeable Transmit/Receive Packet Buffer

This block stores packet bytes between a host and a radio datapath. In its default layout it keeps two independent byte-wide FIFOs of `DEPTH` entries each. One carries transmit data: the host writes it and the radio side pops it. The other carries receive data: the radio side pushes it and the host reads it. Both FIFOs work at the same time, so the host can load the next transmit packet while a received packet is still arriving.

A merge control joins both storage banks into one FIFO of `2*DEPTH` bytes. A direction select then gives the merged FIFO to either transmit or receive. The other direction has no capacity while merged. Each direction has its own clear control. A restore control rewinds the transmit read position to the first byte of the current packet, so the same packet can be sent again without being written a second time. Full, empty, count and sticky error flags are reported for each direction.

Top module: `dual_pkt_fifo`

## Requirements
- R1: With `merge_en`=0, each direction is a separate FIFO of `DEPTH` bytes that returns bytes in write order. Its `*_full` output is 1 exactly when its count equals `DEPTH`.
- R2: With `merge_en`=0, host transmit writes, radio transmit pops, radio receive pushes and host receive reads may all happen in the same cycle, and none of them disturbs the other direction.
- R3: A write to a full FIFO is dropped and leaves the count unchanged. It sets that direction's sticky overflow flag, which stays at 1 until that direction is cleared.
- R4: A pop from an empty FIFO returns all-zero read data on the next cycle. It sets that direction's sticky underflow flag, which stays at 1 until that direction is cleared.
- R5: With `merge_en`=1, one FIFO of `2*DEPTH` bytes serves transmit when `merge_rx_sel`=0 and serves receive when `merge_rx_sel`=1. The unselected direction reports full=1, empty=1 and count=0, and writes to it are dropped as overflows.
- R6: `tx_clear` empties only the transmit FIFO and `rx_clear` empties only the receive FIFO. Each also resets that direction's flags. A clear wins over a push or pop to the same FIFO in the same cycle.
- R7: Any change of `merge_en` or `merge_rx_sel` from its value in the previous cycle empties both FIFOs and resets all four flags.
- R8: `tx_restore` moves the transmit read position back to the first byte of the current packet and sets the count to the number of packet bytes still held. The current packet starts with the first write into an empty transmit FIFO. If more than the capacity has been written since then, only the most recent capacity's worth of bytes is kept. The write position is not changed.
- R9: When a restore and a transmit pop arrive in the same cycle, the pop is discarded and no underflow is raised. A transmit write in the same cycle is kept and is included in the restored packet.
- R10: Read data appears on `radio_rd_data` or `host_rd_data` in the cycle after the pop and holds until the next pop on that side.
- R11: Status outputs reflect an operation in the cycle after it. After reset, both counts are 0, empty=1, full=0, all flags are 0 and both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| merge_en | input | 1 | Join both banks into one FIFO |
| merge_rx_sel | input | 1 | Merged FIFO serves receive (1) or transmit (0) |
| tx_clear | input | 1 | Empty the transmit FIFO |
| rx_clear | input | 1 | Empty the receive FIFO |
| tx_restore | input | 1 | Rewind transmit reads to packet start |
| host_wr_en | input | 1 | Host writes a transmit byte |
| host_wr_data | input | WIDTH | Transmit byte from host |
| radio_rd_en | input | 1 | Radio pops a transmit byte |
| radio_rd_data | output | WIDTH | Transmit byte to radio |
| radio_wr_en | input | 1 | Radio pushes a received byte |
| radio_wr_data | input | WIDTH | Received byte from radio |
| host_rd_en | input | 1 | Host reads a received byte |
| host_rd_data | output | WIDTH | Received byte to host |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_count | output | $clog2(2*DEPTH)+1 | Transmit bytes held |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_count | output | $clog2(2*DEPTH)+1 | Receive bytes held |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_underflow | output | 1 | Sticky receive underflow |

## Verification
The bench builds the block with `DEPTH`=8 and `WIDTH`=8. At this size a split FIFO fills in eight writes and a merged FIFO fills in sixteen, so the random phase reaches full, empty and pointer wrap-around many times. It also sees restores whose packets have grown past the capacity and slid forward. The small depth also lets occasional random mode changes land while both FIFOs still hold data.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  // Capacity of one direction for a given layout.
  function automatic int unsigned side_cap(input logic merged, input logic rx_sel,
                                           input logic is_rx, input int unsigned depth);
    if (!merged) return depth;
    return (rx_sel == is_rx) ? 2 * depth : 0;
  endfunction

endpackage

// File: rtl/dpf_bank.sv
module dpf_bank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int RW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [RW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [RW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dpf_ptr.sv
module dpf_ptr #(
  parameter int DEPTH       = 32,
  parameter bit HAS_RESTORE = 1'b0,
  localparam int AW = $clog2(2 * DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] cap_n,
  input  logic [AW-1:0] base,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          restore,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          pop_miss,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);

  logic [AW-1:0] wr_q, rd_q, wr_n, rd_n, mark_n;
  logic [CW-1:0] cnt_q, cnt_n, len_n;
  logic          full_q, empty_q, ovf_q, udf_q, rs_eff;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] i, input logic [CW-1:0] c);
    return ({1'b0, i} + CW'(1) == c) ? '0 : i + AW'(1);
  endfunction

  assign rs_eff   = HAS_RESTORE ? (restore & ~clr) : 1'b0;
  assign push_ok  = push & ~clr & (cnt_q < cap);
  assign pop_ok   = pop & ~clr & ~rs_eff & (cnt_q != '0);
  assign pop_miss = pop & ~clr & ~rs_eff & (cnt_q == '0);

  generate
    if (HAS_RESTORE) begin : g_restore
      logic [AW-1:0] mark_q;
      logic [CW-1:0] len_q;
      always_comb begin
        mark_n = mark_q;
        len_n  = len_q;
        if (push_ok) begin
          if (cnt_q == '0) begin
            mark_n = wr_q;
            len_n  = CW'(1);
          end else if (len_q == cap) begin
            mark_n = bump(mark_q, cap);
          end else begin
            len_n = len_q + CW'(1);
          end
        end
      end
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          mark_q <= '0;
          len_q  <= '0;
        end else begin
          mark_q <= mark_n;
          len_q  <= len_n;
        end
      end
      // Restore never loses resident bytes.
      assert_restore_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (restore && !clr && !push) |=> (cnt_q >= $past(cnt_q)));
    end else begin : g_plain
      assign mark_n = '0;
      assign len_n  = '0;
    end
  endgenerate

  always_comb begin
    wr_n  = push_ok ? bump(wr_q, cap) : wr_q;
    rd_n  = pop_ok ? bump(rd_q, cap) : rd_q;
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    if (rs_eff) begin
      rd_n  = mark_n;
      cnt_n = len_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      full_q  <= (cap_n == '0);
      empty_q <= 1'b1;
    end else begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      cnt_q   <= cnt_n;
      ovf_q   <= ovf_q | (push & (cnt_q >= cap));
      udf_q   <= udf_q | pop_miss;
      full_q  <= (cnt_n == cap_n);
      empty_q <= (cnt_n == '0);
    end
  end

  assign wr_addr = base + wr_q;
  assign rd_addr = base + rd_q;
  assign count   = cnt_q;
  assign full    = full_q;
  assign empty   = empty_q;
  assign ovf     = ovf_q;
  assign udf     = udf_q;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cap);
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (full_q && push && !pop && !clr && !restore) |=> (cnt_q == $past(cnt_q)));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);
  assert_udf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (udf_q && !clr) |=> udf_q);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && empty_q && !ovf_q && !udf_q));

endmodule

// File: rtl/dpf_rdout.sv
module dpf_rdout #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_ok,
  input  logic             pop_miss,
  input  logic             bank_sel,
  input  logic [WIDTH-1:0] rd0,
  input  logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] data
);

  logic             fresh_q, bank_q;
  logic [WIDTH-1:0] hold_q, shown;

  assign shown = fresh_q ? (bank_q ? rd1 : rd0) : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b0;
      bank_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= pop_ok;
      if (pop_ok) bank_q <= bank_sel;
      hold_q  <= pop_miss ? '0 : shown;
    end
  end

  assign data = shown;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!pop_ok && !pop_miss && !fresh_q) |=> $stable(data));

endmodule

// File: rtl/dual_pkt_fifo.sv
module dual_pkt_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(2 * DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             merge_en,
  input  logic             merge_rx_sel,
  input  logic             tx_clear,
  input  logic             rx_clear,
  input  logic             tx_restore,
  input  logic             host_wr_en,
  input  logic [WIDTH-1:0] host_wr_data,
  input  logic             radio_rd_en,
  output logic [WIDTH-1:0] radio_rd_data,
  input  logic             radio_wr_en,
  input  logic [WIDTH-1:0] radio_wr_data,
  input  logic             host_rd_en,
  output logic [WIDTH-1:0] host_rd_data,
  output logic             tx_full,
  output logic             tx_empty,
  output logic [CW-1:0]    tx_count,
  output logic             tx_overflow,
  output logic             tx_underflow,
  output logic             rx_full,
  output logic             rx_empty,
  output logic [CW-1:0]    rx_count,
  output logic             rx_overflow,
  output logic             rx_underflow
);
  import dpf_pkg::*;

  localparam int RW = AW - 1;

  logic          merge_q, rxsel_q, chg;
  logic [CW-1:0] tx_cap, rx_cap, tx_cap_n, rx_cap_n;
  logic [AW-1:0] rx_base, tx_wa, tx_ra, rx_wa, rx_ra;
  logic          tx_push_ok, tx_pop_ok, tx_miss, rx_push_ok, rx_pop_ok, rx_miss;
  logic [WIDTH-1:0] bank_rd [2];

  initial begin
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) $error("DEPTH must be a power of two >= 2");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      merge_q <= 1'b0;
      rxsel_q <= 1'b0;
    end else begin
      merge_q <= merge_en;
      rxsel_q <= merge_rx_sel;
    end
  end

  assign chg      = (merge_en != merge_q) | (merge_rx_sel != rxsel_q);
  assign tx_cap   = CW'(side_cap(merge_q, rxsel_q, 1'b0, DEPTH));
  assign rx_cap   = CW'(side_cap(merge_q, rxsel_q, 1'b1, DEPTH));
  assign tx_cap_n = rst ? CW'(DEPTH) : CW'(side_cap(merge_en, merge_rx_sel, 1'b0, DEPTH));
  assign rx_cap_n = rst ? CW'(DEPTH) : CW'(side_cap(merge_en, merge_rx_sel, 1'b1, DEPTH));
  assign rx_base  = merge_q ? '0 : AW'(DEPTH);

  dpf_ptr #(.DEPTH(DEPTH), .HAS_RESTORE(1'b1)) u_tx (
    .clk, .rst, .cap(tx_cap), .cap_n(tx_cap_n), .base('0),
    .clr(tx_clear | chg), .push(host_wr_en), .pop(radio_rd_en), .restore(tx_restore),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .pop_miss(tx_miss),
    .wr_addr(tx_wa), .rd_addr(tx_ra), .count(tx_count), .full(tx_full),
    .empty(tx_empty), .ovf(tx_overflow), .udf(tx_underflow));

  dpf_ptr #(.DEPTH(DEPTH), .HAS_RESTORE(1'b0)) u_rx (
    .clk, .rst, .cap(rx_cap), .cap_n(rx_cap_n), .base(rx_base),
    .clr(rx_clear | chg), .push(radio_wr_en), .pop(host_rd_en), .restore(1'b0),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .pop_miss(rx_miss),
    .wr_addr(rx_wa), .rd_addr(rx_ra), .count(rx_count), .full(rx_full),
    .empty(rx_empty), .ovf(rx_overflow), .udf(rx_underflow));

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic tw, rw, tr, rr;
      assign tw = tx_push_ok & (tx_wa[AW-1] == 1'(b));
      assign rw = rx_push_ok & (rx_wa[AW-1] == 1'(b));
      assign tr = tx_pop_ok & (tx_ra[AW-1] == 1'(b));
      assign rr = rx_pop_ok & (rx_ra[AW-1] == 1'(b));

      dpf_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk,
        .we(tw | rw),
        .waddr(tw ? tx_wa[RW-1:0] : rx_wa[RW-1:0]),
        .wdata(tw ? host_wr_data : radio_wr_data),
        .re(tr | rr),
        .raddr(tr ? tx_ra[RW-1:0] : rx_ra[RW-1:0]),
        .rdata(bank_rd[b]));
    end
  endgenerate

  dpf_rdout #(.WIDTH(WIDTH)) u_tx_out (
    .clk, .rst, .pop_ok(tx_pop_ok), .pop_miss(tx_miss), .bank_sel(tx_ra[AW-1]),
    .rd0(bank_rd[0]), .rd1(bank_rd[1]), .data(radio_rd_data));

  dpf_rdout #(.WIDTH(WIDTH)) u_rx_out (
    .clk, .rst, .pop_ok(rx_pop_ok), .pop_miss(rx_miss), .bank_sel(rx_ra[AW-1]),
    .rd0(bank_rd[0]), .rd1(bank_rd[1]), .data(host_rd_data));

  assert_inactive_rx_R5: assert property (@(posedge clk) disable iff (rst)
    (merge_q && !rxsel_q) |-> (rx_full && rx_empty && rx_count == '0));
  assert_inactive_tx_R5: assert property (@(posedge clk) disable iff (rst)
    (merge_q && rxsel_q) |-> (tx_full && tx_empty && tx_count == '0));
  assert_mode_change_R7: assert property (@(posedge clk) disable iff (rst)
    chg |=> (tx_count == '0 && rx_count == '0 && !tx_overflow && !rx_overflow
             && !tx_underflow && !rx_underflow));
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && rx_empty && !rx_clear && !chg) |=> (host_rd_data == '0));

endmodule

// File: tb/test_dual_pkt_fifo.sv
module test_dual_pkt_fifo;
  localparam int D  = 8;
  localparam int W  = 8;
  localparam int CW = $clog2(2 * D) + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic merge_en = 0, merge_rx_sel = 0, tx_clear = 0, rx_clear = 0, tx_restore = 0;
  logic host_wr_en = 0, radio_rd_en = 0, radio_wr_en = 0, host_rd_en = 0;
  logic [W-1:0] host_wr_data = '0, radio_wr_data = '0;
  logic [W-1:0] radio_rd_data, host_rd_data;
  logic tx_full, tx_empty, tx_overflow, tx_underflow;
  logic rx_full, rx_empty, rx_overflow, rx_underflow;
  logic [CW-1:0] tx_count, rx_count;

  dual_pkt_fifo #(.DEPTH(D), .WIDTH(W)) i_dual_pkt_fifo (.*);

  int checks = 0, errors = 0;
  string ctx = "R11 reset";
  bit done = 0;

  // Reference model state
  logic [W-1:0] txq[$], pkt[$], rxq[$];
  logic [W-1:0] e_radio = '0, e_host = '0;
  bit tovf = 0, tudf = 0, rovf = 0, rudf = 0, m_q = 0, s_q = 0;

  function automatic int capf(bit m, bit s, bit rx);
    if (!m) return D;
    return (s == rx) ? 2 * D : 0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", ctx, what, act, exp);
    end
  endtask

  task automatic model();
    bit chg, rs, pu, po;
    int ct, cr, n0;
    chg = (merge_en != m_q) || (merge_rx_sel != s_q);
    ct = capf(m_q, s_q, 0);
    cr = capf(m_q, s_q, 1);
    if (tx_clear || chg) begin
      txq.delete(); pkt.delete(); tovf = 0; tudf = 0;
    end else begin
      rs = tx_restore;
      n0 = txq.size();
      pu = host_wr_en && n0 < ct;
      po = radio_rd_en && !rs && n0 > 0;
      if (host_wr_en && !pu) tovf = 1;
      if (radio_rd_en && !rs && n0 == 0) begin tudf = 1; e_radio = '0; end
      if (po) e_radio = txq.pop_front();
      if (pu) begin
        if (n0 == 0) pkt.delete();
        pkt.push_back(host_wr_data);
        if (pkt.size() > ct) void'(pkt.pop_front());
        txq.push_back(host_wr_data);
      end
      if (rs) txq = pkt;
    end
    if (rx_clear || chg) begin
      rxq.delete(); rovf = 0; rudf = 0;
    end else begin
      n0 = rxq.size();
      pu = radio_wr_en && n0 < cr;
      po = host_rd_en && n0 > 0;
      if (radio_wr_en && !pu) rovf = 1;
      if (host_rd_en && n0 == 0) begin rudf = 1; e_host = '0; end
      if (po) e_host = rxq.pop_front();
      if (pu) rxq.push_back(radio_wr_data);
    end
    m_q = merge_en;
    s_q = merge_rx_sel;
  endtask

  task automatic check_all();
    chk("tx_count", tx_count, txq.size());
    chk("tx_full", tx_full, txq.size() == capf(m_q, s_q, 0));
    chk("tx_empty", tx_empty, txq.size() == 0);
    chk("tx_overflow", tx_overflow, tovf);
    chk("tx_underflow", tx_underflow, tudf);
    chk("radio_rd_data", radio_rd_data, e_radio);
    chk("rx_count", rx_count, rxq.size());
    chk("rx_full", rx_full, rxq.size() == capf(m_q, s_q, 1));
    chk("rx_empty", rx_empty, rxq.size() == 0);
    chk("rx_overflow", rx_overflow, rovf);
    chk("rx_underflow", rx_underflow, rudf);
    chk("host_rd_data", host_rd_data, e_host);
  endtask

  // Inputs are driven at a falling edge; outputs are compared at the next one.
  task automatic step();
    model();
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    tx_clear = 0; rx_clear = 0; tx_restore = 0;
    host_wr_en = 0; radio_rd_en = 0; radio_wr_en = 0; host_rd_en = 0;
  endtask

  task automatic hw(int n);
    for (int i = 0; i < n; i++) begin
      quiet(); host_wr_en = 1; host_wr_data = W'($urandom); step();
    end
    quiet();
  endtask

  task automatic rp(int n);
    for (int i = 0; i < n; i++) begin quiet(); radio_rd_en = 1; step(); end
    quiet();
  endtask

  task automatic rw(int n);
    for (int i = 0; i < n; i++) begin
      quiet(); radio_wr_en = 1; radio_wr_data = W'($urandom); step();
    end
    quiet();
  endtask

  task automatic hr(int n);
    for (int i = 0; i < n; i++) begin quiet(); host_rd_en = 1; step(); end
    quiet();
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    check_all();              // R11 reset values
    step();

    ctx = "R1 fill split tx / R3 overflow";
    hw(D + 1);
    ctx = "R10 pop order / R4 underflow";
    rp(D + 1);

    ctx = "R2 concurrent split traffic";
    for (int i = 0; i < D; i++) begin
      quiet(); host_wr_en = 1; host_wr_data = W'(i + 8'h40);
      radio_wr_en = 1; radio_wr_data = W'(i + 8'h80); step();
    end
    for (int i = 0; i < D; i++) begin
      quiet(); radio_rd_en = 1; host_rd_en = 1; step();
    end
    quiet(); step();

    ctx = "R6 clear tx only";
    tx_clear = 1; host_wr_en = 1; radio_wr_en = 1; radio_wr_data = 8'h11; step();
    quiet(); rx_clear = 1; host_rd_en = 1; step();
    quiet(); step();

    ctx = "R8 restore rewinds packet";
    hw(5); rp(3);
    quiet(); tx_restore = 1; step();
    rp(6);
    ctx = "R9 restore beats pop, keeps push";
    hw(3); rp(1);
    quiet(); tx_restore = 1; radio_rd_en = 1; host_wr_en = 1; host_wr_data = 8'hA5; step();
    rp(5);
    ctx = "R8 sliding packet window";
    hw(D); rp(4); hw(3);
    quiet(); tx_restore = 1; step();
    rp(D + 1);

    ctx = "R7 mode change clears / R5 merged tx";
    rw(3);
    quiet(); merge_en = 1; step();
    hw(2 * D + 1);
    rw(1);
    rp(2 * D + 1);

    ctx = "R5 merged rx";
    hw(2);
    quiet(); merge_rx_sel = 1; step();
    rw(2 * D + 1);
    hw(1);
    hr(2 * D + 1);
    quiet(); merge_en = 0; merge_rx_sel = 0; step();

    ctx = "R2 random mix";
    for (int i = 0; i < 6000; i++) begin
      int r;
      quiet();
      host_wr_en  = ($urandom % 100) < 45;
      radio_rd_en = ($urandom % 100) < 40;
      radio_wr_en = ($urandom % 100) < 45;
      host_rd_en  = ($urandom % 100) < 40;
      host_wr_data  = W'($urandom);
      radio_wr_data = W'($urandom);
      tx_restore = ($urandom % 100) < 4;
      tx_clear   = ($urandom % 100) < 2;
      rx_clear   = ($urandom % 100) < 2;
      r = $urandom % 1000;
      if (r < 6) merge_en = ~merge_en;
      else if (r < 12) merge_rx_sel = ~merge_rx_sel;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule